// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital front end of a two-channel converter. A host writes to it over a 16-bit parallel bus. Each write goes into either the code staging register or the range staging register of the addressed channel. An update strobe then moves every staging register into its live register at the same moment. The live registers alone drive the outputs: the per-channel conversion code and the 3-bit range selector. Staging a new range and a new code first, and committing them together, lets the analog side change range without an intermediate glitch. It also lets both channels change on the same cycle.

The write strobe, update strobe, code/range select and clear pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer before use. The chip-select address and the bus data are sampled directly, so they must be held stable while a strobe is active. The strobe lines act on level: the staging stage follows the bus while the synchronized write strobe is low, and the live stage follows the staging stage while the synchronized update strobe is high. Tying both strobes to one slow clock therefore gives master-slave capture, and holding write low with update high makes the path transparent. A one-cycle settle pulse marks each rising edge of the update strobe. A clear sets the code registers to the zero-volt code of each channel's live range and leaves the range registers alone. Any staging register can be read back on a separate port.

Top module: `dacfe_top`

## Requirements
- R1: While the synchronized write strobe `wr_n` is low and `sel_span` is 0, the code staging register of each addressed channel takes `bus_wdata[13:0]`.
- R2: While the synchronized `wr_n` is low and `sel_span` is 1, the range staging register of each addressed channel takes `bus_wdata[2:0]`. A range write leaves the code staging register unchanged.
- R3: A write of either kind never changes `code_a`, `code_b`, `span_a` or `span_b`.
- R4: While the synchronized `upd` is high, both channels copy code and range from staging to live together. If nothing was written since the last update, the outputs keep their values.
- R5: `chan_sel` decides which channels a write reaches: 00 is channel A only, 01 is channel B only, 11 is both channels, and 10 is neither.
- R6: Each rising edge of `upd` produces `settle_pulse` high for exactly one clock, on the third rising clock edge after the pin rises.
- R7: While the synchronized `clr_n` is low, the staging and live code registers of both channels take the clear code of that channel's live range. Ranges 0 and 1 clear to 0x0000. Ranges 2, 3 and 4 clear to 0x2000. Range 5 clears to 0x1000. Ranges 6 and 7 clear to 0x0000. Clear takes priority over writes.
- R8: A clear changes neither the staging nor the live range registers.
- R9: With `wr_n` held low and `upd` held high, changes on the bus reach the addressed channel's code output a few cycles later.
- R10: With `wr_n` and `upd` driven by one shared strobe, the staging register captures while the strobe is low. The live register takes that value when the strobe rises and holds it until the next rise.
- R11: `rd_data` shows a staging register, zero-extended. `chan_sel` 01 selects channel B and every other value selects channel A. `sel_span` 0 selects the code register and 1 selects the range register.
- R12: A synchronous reset with `rst_n` low clears all eight registers to 0 and holds `settle_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wdata | input | 16 | Parallel write bus |
| chan_sel | input | 2 | Channel address |
| sel_span | input | 1 | 0 selects code registers, 1 selects range registers |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| upd | input | 1 | Active-high update strobe (asynchronous) |
| clr_n | input | 1 | Active-low clear (asynchronous) |
| rd_data | output | 16 | Readback of the selected staging register |
| code_a | output | 14 | Live code, channel A |
| code_b | output | 14 | Live code, channel B |
| span_a | output | 3 | Live range, channel A |
| span_b | output | 3 | Live range, channel B |
| settle_pulse | output | 1 | One-clock pulse on each update rising edge |

## Verification
A seeded random mix of code writes, range writes, updates and clears covers all four addresses, including the unused one. Checking readback after each write, before any update, separates the staging path from the live path. Comparing the live outputs after each update shows whether code and range commit together and whether an update with no write in between is harmless. Clears issued under every range value show whether the clear code follows the live range and leaves the range registers alone. Directed sequences cover the transparent strobe setting, the shared-strobe master-slave setting, and the exact cycle and width of the settle pulse.

// File: rtl/dacfe_pkg.sv
// Package dacfe_pkg
// Shared widths, the range encoding and the clear-code rule for the
// converter register front end. Assumes a 14-bit code and a 3-bit range.
package dacfe_pkg;
    localparam int CODE_W = 14;
    localparam int SPAN_W = 3;
    localparam int BUS_W  = 16;

    typedef enum logic [SPAN_W-1:0] {
        RNG_UNI_LO  = 3'd0,
        RNG_UNI_HI  = 3'd1,
        RNG_BIP_SM  = 3'd2,
        RNG_BIP_MD  = 3'd3,
        RNG_BIP_LG  = 3'd4,
        RNG_BIP_OFS = 3'd5,
        RNG_RSV6    = 3'd6,
        RNG_RSV7    = 3'd7
    } range_e;

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W-1);
    localparam logic [CODE_W-1:0] QTR_CODE = CODE_W'(1) << (CODE_W-2);

    // Zero-volt code for a given live range
    function automatic logic [CODE_W-1:0] zero_code(input logic [SPAN_W-1:0] rng);
        case (range_e'(rng))
            RNG_BIP_SM, RNG_BIP_MD, RNG_BIP_LG: zero_code = MID_CODE;
            RNG_BIP_OFS:                        zero_code = QTR_CODE;
            default:                            zero_code = '0;
        endcase
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
// Module dacfe_sync
// Multi-stage synchronizer for a vector of independent asynchronous control
// lines. Each bit resets to its own value from RST_VAL. Assumes the bits need
// no mutual coherence.
module dacfe_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    // Shift the raw lines through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dacfe_chan.sv
// Module dacfe_chan
// One converter channel: code and range staging registers, each feeding a
// live register. Staging loads on a write enable; live follows staging while
// update is high; clear forces both code registers to the zero code of the
// live range and never touches the ranges. Assumes wr_en is already gated off
// during clear.
module dacfe_chan
    import dacfe_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int SW = SPAN_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_span,
    input  logic [BW-1:0] bus,
    input  logic          upd_lvl,
    input  logic          clr_lvl,
    output logic [CW-1:0] stg_code,
    output logic [SW-1:0] stg_span,
    output logic [CW-1:0] live_code,
    output logic [SW-1:0] live_span
);
    logic [CW-1:0] clr_val;
    assign clr_val = zero_code(live_span);

    // Code staging register: clear first, then code write
    always_ff @(posedge clk) begin
        if (!rst_n)                   stg_code <= '0;
        else if (clr_lvl)             stg_code <= clr_val;
        else if (wr_en && !wr_span)   stg_code <= bus[CW-1:0];
    end

    // Range staging register: range write only, immune to clear
    always_ff @(posedge clk) begin
        if (!rst_n)                   stg_span <= '0;
        else if (wr_en && wr_span)    stg_span <= bus[SW-1:0];
    end

    // Live code register: clear first, then update copy
    always_ff @(posedge clk) begin
        if (!rst_n)                   live_code <= '0;
        else if (clr_lvl)             live_code <= clr_val;
        else if (upd_lvl)             live_code <= stg_code;
    end

    // Live range register: update copy only
    always_ff @(posedge clk) begin
        if (!rst_n)                   live_span <= '0;
        else if (upd_lvl)             live_span <= stg_span;
    end

    // R3/R4: with no update and no clear the live code holds
    a_r3_live_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_lvl && !clr_lvl) |=> $stable(live_code));

    // R4: with no update the live range holds
    a_r4_live_span_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_lvl |=> $stable(live_span));

    // R7: a clear lands the zero code of the previous live range
    a_r7_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lvl |=> (live_code == zero_code($past(live_span))) &&
                    (stg_code == zero_code($past(live_span))));

    // R8: clear leaves the staging range alone
    a_r8_clear_keeps_span: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lvl |=> $stable(stg_span));
endmodule

// File: rtl/dacfe_top.sv
// Module dacfe_top
// Two-channel double-buffered register front end. Synchronizes the strobe
// and select pins, decodes the channel address, builds the settle pulse on
// the update rising edge, and muxes a staging register onto the read port.
// Assumes chan_sel and bus_wdata stay stable while a strobe is active.
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int CW        = CODE_W,
    parameter int SW        = SPAN_W,
    parameter int BW        = BUS_W,
    parameter int SYNC_STG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bus_wdata,
    input  logic [1:0]    chan_sel,
    input  logic          sel_span,
    input  logic          wr_n,
    input  logic          upd,
    input  logic          clr_n,
    output logic [BW-1:0] rd_data,
    output logic [CW-1:0] code_a,
    output logic [CW-1:0] code_b,
    output logic [SW-1:0] span_a,
    output logic [SW-1:0] span_b,
    output logic          settle_pulse
);
    localparam int NCH   = 2;
    localparam int NCTRL = 4;
    localparam logic [NCTRL-1:0] CTRL_RST = 4'b1001; // clr_n, upd, sel, wr_n

    logic [NCTRL-1:0] ctrl_raw, ctrl_s;
    logic wr_lvl, upd_lvl, sel_s, clr_lvl, upd_prev;
    logic [NCH-1:0] ch_hit;

    logic [CW-1:0] stg_code  [NCH];
    logic [SW-1:0] stg_span  [NCH];
    logic [CW-1:0] live_code [NCH];
    logic [SW-1:0] live_span [NCH];

    assign ctrl_raw = {clr_n, upd, sel_span, wr_n};

    dacfe_sync #(.W(NCTRL), .STAGES(SYNC_STG), .RST_VAL(CTRL_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ctrl_raw),
        .q_sync  (ctrl_s)
    );

    assign wr_lvl  = !ctrl_s[0];
    assign sel_s   =  ctrl_s[1];
    assign upd_lvl =  ctrl_s[2];
    assign clr_lvl = !ctrl_s[3];

    // Address decode: bit 0 picks B, both bits set broadcast, 10 reaches none
    always_comb begin
        case (chan_sel)
            2'b00:   ch_hit = 2'b01;
            2'b01:   ch_hit = 2'b10;
            2'b11:   ch_hit = 2'b11;
            default: ch_hit = 2'b00;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            dacfe_chan #(.CW(CW), .SW(SW), .BW(BW)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_lvl && ch_hit[g] && !clr_lvl),
                .wr_span   (sel_s),
                .bus       (bus_wdata),
                .upd_lvl   (upd_lvl),
                .clr_lvl   (clr_lvl),
                .stg_code  (stg_code[g]),
                .stg_span  (stg_span[g]),
                .live_code (live_code[g]),
                .live_span (live_span[g])
            );
        end
    endgenerate

    // Settle pulse on the synchronized update rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_prev     <= 1'b0;
            settle_pulse <= 1'b0;
        end else begin
            upd_prev     <= upd_lvl;
            settle_pulse <= upd_lvl && !upd_prev;
        end
    end

    // Readback mux of a staging register, zero-extended
    always_comb begin
        logic idx;
        idx = (chan_sel == 2'b01);
        if (sel_span) rd_data = BW'(stg_span[idx]);
        else          rd_data = BW'(stg_code[idx]);
    end

    assign code_a = live_code[0];
    assign code_b = live_code[1];
    assign span_a = live_span[0];
    assign span_b = live_span[1];

    // R6: the settle pulse never lasts two cycles
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        settle_pulse |=> !settle_pulse);

    // R5: a write to address 10 reaches no staging register
    a_r5_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lvl && chan_sel == 2'b10 && !clr_lvl) |=>
            $stable(stg_code[0]) && $stable(stg_code[1]) &&
            $stable(stg_span[0]) && $stable(stg_span[1]));

    // R3: outputs stay put while only writes happen
    a_r3_write_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_lvl && !clr_lvl) |=> $stable(code_a) && $stable(code_b) &&
                                   $stable(span_a) && $stable(span_b));
endmodule

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_wdata;
    logic [1:0]  chan_sel;
    logic        sel_span, wr_n, upd, clr_n;
    logic [15:0] rd_data;
    logic [13:0] code_a, code_b;
    logic [2:0]  span_a, span_b;
    logic        settle_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [13:0] m_sc [2];
    logic [2:0]  m_ss [2];
    logic [13:0] m_lc [2];
    logic [2:0]  m_ls [2];

    always #4 clk = ~clk;

    dacfe_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .chan_sel(chan_sel),
        .sel_span(sel_span), .wr_n(wr_n), .upd(upd), .clr_n(clr_n),
        .rd_data(rd_data), .code_a(code_a), .code_b(code_b),
        .span_a(span_a), .span_b(span_b), .settle_pulse(settle_pulse)
    );

    function automatic logic [13:0] exp_clear(input logic [2:0] r);
        if (r >= 3'd2 && r <= 3'd4) return 14'h2000;
        if (r == 3'd5)              return 14'h1000;
        return 14'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " code_a"}, 32'(code_a), 32'(m_lc[0]));
        chk({req, " code_b"}, 32'(code_b), 32'(m_lc[1]));
        chk({req, " span_a"}, 32'(span_a), 32'(m_ls[0]));
        chk({req, " span_b"}, 32'(span_b), 32'(m_ls[1]));
    endtask

    task automatic chk_readback(input string req);
        for (int c = 0; c < 2; c++) begin
            chan_sel = c[0] ? 2'b01 : 2'b00;
            sel_span = 1'b0; #1;
            chk({req, " rd code"}, 32'(rd_data), 32'(m_sc[c]));
            sel_span = 1'b1; #1;
            chk({req, " rd span"}, 32'(rd_data), 32'(m_ss[c]));
        end
        sel_span = 1'b0;
        wait_n(3);
    endtask

    task automatic do_write(input logic [1:0] a, input logic s, input logic [15:0] d);
        chan_sel = a; sel_span = s; bus_wdata = d;
        wait_n(3);
        wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(4);
        for (int c = 0; c < 2; c++) begin
            logic hit;
            hit = (a == 2'b11) || (a == 2'b00 && c == 0) || (a == 2'b01 && c == 1);
            if (hit) begin
                if (s) m_ss[c] = d[2:0];
                else   m_sc[c] = d[13:0];
            end
        end
    endtask

    task automatic do_update();
        upd = 1'b1;
        wait_n(2);
        chk("R6 pulse low before edge", 32'(settle_pulse), 0);
        wait_n(1);
        chk("R6 pulse high", 32'(settle_pulse), 1);
        wait_n(1);
        chk("R6 pulse width", 32'(settle_pulse), 0);
        upd = 1'b0;
        wait_n(4);
        for (int c = 0; c < 2; c++) begin m_lc[c] = m_sc[c]; m_ls[c] = m_ss[c]; end
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        wait_n(5);
        clr_n = 1'b1;
        wait_n(4);
        for (int c = 0; c < 2; c++) begin
            m_lc[c] = exp_clear(m_ls[c]);
            m_sc[c] = m_lc[c];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        seed = 32'd20240611;
        r = $urandom(seed);
        rst_n = 1'b0; bus_wdata = '0; chan_sel = 2'b00; sel_span = 1'b0;
        wr_n = 1'b1; upd = 1'b0; clr_n = 1'b1;
        for (int c = 0; c < 2; c++) begin m_sc[c]=0; m_ss[c]=0; m_lc[c]=0; m_ls[c]=0; end
        wait_n(5);
        chk("R12 reset pulse", 32'(settle_pulse), 0);
        chk_outputs("R12 reset");
        rst_n = 1'b1;
        wait_n(4);
        chk_readback("R12 reset staging");

        // R1/R2/R3: directed writes, outputs untouched before update
        do_write(2'b00, 1'b0, 16'h3ABC);
        do_write(2'b01, 1'b1, 16'hFFF5);
        chk_outputs("R3 writes hidden");
        chk_readback("R1 R2 R11 staging");
        do_update();
        chk_outputs("R4 update both");
        do_update();
        chk_outputs("R4 update no write");

        // R5: unmapped address and broadcast
        do_write(2'b10, 1'b0, 16'h1111);
        chk_readback("R5 unmapped ignored");
        do_write(2'b11, 1'b0, 16'h0777);
        chk_readback("R5 broadcast");

        // R7/R8: clear under offset bipolar range on B, unipolar on A
        do_clear();
        chk_outputs("R7 R8 clear");
        chk_readback("R7 R8 clear staging");

        // R9: transparent mode
        chan_sel = 2'b00; sel_span = 1'b0; bus_wdata = 16'h1234;
        wr_n = 1'b0; upd = 1'b1;
        wait_n(6);
        chk("R9 transparent 1", 32'(code_a), 32'h1234);
        bus_wdata = 16'h2ACE;
        wait_n(6);
        chk("R9 transparent 2", 32'(code_a), 32'h2ACE);
        wr_n = 1'b1;
        wait_n(4);
        upd = 1'b0;
        wait_n(4);
        m_sc[0] = 14'h2ACE;
        for (int c = 0; c < 2; c++) begin m_lc[c] = m_sc[c]; m_ls[c] = m_ss[c]; end
        chk_outputs("R9 after transparent");

        // R10: shared strobe master-slave
        chan_sel = 2'b01; sel_span = 1'b0; bus_wdata = 16'h0F0F;
        wait_n(2);
        wr_n = 1'b0; upd = 1'b0;
        wait_n(8);
        wr_n = 1'b1; upd = 1'b1;
        wait_n(4);
        bus_wdata = 16'h00A5;
        wait_n(4);
        chk("R10 slave takes low-phase value", 32'(code_b), 32'h0F0F);
        wr_n = 1'b0; upd = 1'b0;
        wait_n(8);
        chk("R10 slave holds during low", 32'(code_b), 32'h0F0F);
        wr_n = 1'b1; upd = 1'b1;
        wait_n(8);
        chk("R10 slave next value", 32'(code_b), 32'h00A5);
        upd = 1'b0;
        wait_n(4);
        m_sc[1] = 14'h00A5;
        for (int c = 0; c < 2; c++) begin m_lc[c] = m_sc[c]; m_ls[c] = m_ss[c]; end
        chk_outputs("R10 after master-slave");

        // Random mix: R1 R2 R4 R5 R7 R8 R11
        for (int i = 0; i < 160; i++) begin
            int unsigned op;
            op = $urandom % 8;
            if (op < 5) do_write(2'($urandom), 1'($urandom), 16'($urandom));
            else if (op < 7) do_update();
            else do_clear();
            chk_outputs("R1 R2 R4 R7 R8 random");
            chk_readback("R5 R11 random");
        end

        // R7: clear code for each range value on both channels
        for (int rv = 0; rv < 8; rv++) begin
            do_write(2'b11, 1'b1, 16'(rv));
            do_write(2'b11, 1'b0, 16'h3333);
            do_update();
            do_clear();
            chk_outputs("R7 per range");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule